// File: doc/BRIEF.md
# PHY Register Access Sequencer

This block lets a host perform single-byte register reads and writes on a PHY device that sits behind a slow parallel bus. The bus has a 9-bit address, an 8-bit data path and three strobes: an active-low chip enable, an active-low output enable and a direction select. The data path is brought out as separate input, output and output-enable signals, so the pad ring can form the tri-state pin. Each access runs a fixed, cycle-counted strobe pattern. Writes and reads use different phase sequences.

The host presents a request with an address, a direction and write data. The request is taken in a cycle where `req_ready` is high. When the access finishes, the host sees a one-cycle `acc_done` pulse, and read data stays on `rd_data` until the next read captures a new byte.

The block also produces a bounded reset pulse for the PHY. The pulse starts on hardware reset and on a software request, and a software request also abandons any access in flight. The PHY's active-low interrupt line is registered on the clock and presented to the host as an active-high flag.

Top module: `phy_regbus_seq`

## Requirements
- R1: While `rst_n` is low: `phy_ce_n`=1, `phy_oe_n`=1, `phy_dout_en`=0, `acc_done`=0, `req_ready`=0 and `phy_rst_n`=0.
- R2: A write accepted at edge E0 follows this pattern, counting cycle k as the cycle after the k-th edge from E0.
  - Cycles 1 to 6: `phy_rw`=0, address driven and data driven (`phy_dout_en`=1, `phy_dout`=write data).
  - Cycle 1: `phy_ce_n`=1.
  - Cycles 2 to 5: `phy_ce_n`=0.
  - Cycle 6: `phy_ce_n`=1.
  - Cycle 7: the data bus is released.
  - Throughout: `phy_oe_n`=1.
- R3: A read accepted at E0 follows this pattern.
  - Cycles 1 to 6: `phy_rw`=1 and `phy_ce_n`=0.
  - Cycles 2 to 5: `phy_oe_n`=0, which is always inside the chip-enable window.
  - Throughout: `phy_dout_en`=0.
- R4: A read captures `phy_din` at the edge where `phy_oe_n` rises, which is the edge ending cycle 5. The value is on `rd_data` from cycle 6 and does not change until a later read captures a new byte; writes leave it unchanged.
- R5: `acc_done` is high for exactly one cycle, which is cycle 7 of an access. In that cycle every strobe is inactive and the data bus is released.
- R6: When `req_ready` is low, `req` is ignored.
  - `req_ready` is low during an access and during the PHY reset pulse.
  - A request raised in that time leaves the address and strobes untouched.
  - The request does not start an access later.
- R7: After `rst_n` rises, `phy_rst_n` stays low for RST_LEN cycles, which is 16 by default and always within 11 to 22.
- R8: A `soft_rst` sampled high does the following.
  - `phy_rst_n` goes low in the next cycle for RST_LEN cycles.
  - Any access in progress is abandoned: strobes go inactive and the bus is released in the next cycle, and no `acc_done` pulse is produced.
- R9: `phy_irq` equals the inverse of `phy_irq_n` as sampled at the previous clock edge, with a reset value of 0.
- R10: When idle, `phy_ce_n`=1, `phy_oe_n`=1, `phy_rw`=1 and `phy_dout_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset request, sampled on the clock |
| req | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | PHY register address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | A request is accepted in this cycle if `req` is high |
| acc_done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read from the PHY |
| phy_addr | output | 9 | PHY address bus |
| phy_dout | output | 8 | Data driven toward the PHY |
| phy_dout_en | output | 1 | Output enable for the data pins |
| phy_din | input | 8 | Data received from the PHY |
| phy_ce_n | output | 1 | Active-low chip enable |
| phy_oe_n | output | 1 | Active-low output enable |
| phy_rw | output | 1 | 1 = read, 0 = write |
| phy_rst_n | output | 1 | Active-low PHY reset |
| phy_irq_n | input | 1 | Active-low PHY interrupt |
| phy_irq | output | 1 | Registered interrupt, active high |

## Verification
The hardest situation to reach from the ports is a software reset that lands mid-strobe. The bench drives `soft_rst` in the third cycle of a write, while chip enable is low. It then checks that the strobes drop in the next cycle, that the reset pulse has the right length, and that no completion pulse ever follows.

Two capture properties are also checked:
- The PHY model puts the true byte on the data pins only while output enable is low, and its inverse at all other times. Any capture outside the rising edge of output enable therefore shows up as a wrong value.
- Holding requests are checked by raising `req` with a different address both during an access and during a reset pulse.

// File: rtl/phy_regbus_seq.sv
module phy_regbus_seq #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int WR_SETUP   = 1,
  parameter int WR_STROBE  = 4,
  parameter int WR_HOLD    = 1,
  parameter int RD_STROBE  = 6,
  parameter int RD_OE_LEAD = 1,
  parameter int RD_OE_LEN  = 4,
  parameter int RST_LEN    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              acc_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_dout,
  output logic              phy_dout_en,
  input  logic [DATA_W-1:0] phy_din,
  output logic              phy_ce_n,
  output logic              phy_oe_n,
  output logic              phy_rw,
  output logic              phy_rst_n,
  input  logic              phy_irq_n,
  output logic              phy_irq
);

  localparam int PH_MAX = (RD_STROBE > WR_STROBE) ? RD_STROBE : WR_STROBE;
  localparam int CNT_W  = $clog2(PH_MAX + WR_SETUP + WR_HOLD + 1);
  localparam int RST_W  = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] C_WSET = CNT_W'(WR_SETUP - 1);
  localparam logic [CNT_W-1:0] C_WSTB = CNT_W'(WR_STROBE - 1);
  localparam logic [CNT_W-1:0] C_WHLD = CNT_W'(WR_HOLD - 1);
  localparam logic [CNT_W-1:0] C_RD   = CNT_W'(RD_STROBE - 1);
  localparam logic [CNT_W-1:0] OE_HI  = CNT_W'(RD_STROBE - 1 - RD_OE_LEAD);
  localparam logic [CNT_W-1:0] OE_LO  = CNT_W'(RD_STROBE - RD_OE_LEAD - RD_OE_LEN);
  localparam logic [RST_W-1:0] RST_LOAD = RST_W'(RST_LEN);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WSTB, S_WHLD, S_RD} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [RST_W-1:0]  rcnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              oe_win;

  assign req_ready   = (state == S_IDLE) && (rcnt == '0);
  assign oe_win      = (state == S_RD) && (cnt <= OE_HI) && (cnt >= OE_LO);
  assign phy_ce_n    = !((state == S_WSTB) || (state == S_RD));
  assign phy_oe_n    = !oe_win;
  assign phy_rw      = !((state == S_WSET) || (state == S_WSTB) || (state == S_WHLD));
  assign phy_dout_en = !phy_rw;
  assign phy_dout    = wdata_q;
  assign phy_addr    = addr_q;
  assign phy_rst_n   = (rcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= RST_LOAD;
    end else if (soft_rst) begin
      rcnt <= RST_LOAD;
    end else if (rcnt != '0) begin
      rcnt <= rcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phy_irq <= 1'b0;
    else        phy_irq <= !phy_irq_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      acc_done <= 1'b0;
    end else if (soft_rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      acc_done <= 1'b0;
    end else begin
      acc_done <= 1'b0;
      if (state != S_IDLE && cnt != '0) cnt <= cnt - 1'b1;
      case (state)
        S_IDLE: if (req && req_ready) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (req_write) begin
            state <= S_WSET;
            cnt   <= C_WSET;
          end else begin
            state <= S_RD;
            cnt   <= C_RD;
          end
        end
        S_WSET: if (cnt == '0) begin
          state <= S_WSTB;
          cnt   <= C_WSTB;
        end
        S_WSTB: if (cnt == '0) begin
          state <= S_WHLD;
          cnt   <= C_WHLD;
        end
        S_WHLD: if (cnt == '0) begin
          state    <= S_IDLE;
          acc_done <= 1'b1;
        end
        S_RD: begin
          if (cnt == OE_LO) rd_data <= phy_din;
          if (cnt == '0) begin
            state    <= S_IDLE;
            acc_done <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_oe_in_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_oe_n |-> !phy_ce_n);
  assert_no_drive_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_oe_n |-> !phy_dout_en);
  assert_strobe_write_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_ce_n && !phy_rw) |-> phy_dout_en);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);
  assert_done_bus_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> (phy_ce_n && phy_oe_n && !phy_dout_en));
  assert_holdoff_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_rst_n && phy_ce_n && !phy_dout_en) |=> (phy_ce_n && !phy_dout_en));
  assert_soft_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (phy_ce_n && phy_oe_n && !phy_dout_en && !acc_done && !phy_rst_n));
  assert_irq_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phy_irq == !$past(phy_irq_n)));

endmodule

// File: tb/phy_regbus_seq_tb.sv
module phy_regbus_seq_tb;
  localparam int RST_LEN = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, soft_rst, req, req_write;
  logic [8:0] req_addr;
  logic [7:0] req_wdata, rd_data, phy_dout, phy_din, rsp_val;
  logic       req_ready, acc_done, phy_dout_en, phy_ce_n, phy_oe_n, phy_rw;
  logic       phy_rst_n, phy_irq_n, phy_irq;
  logic [8:0] phy_addr;

  assign phy_din = phy_oe_n ? ~rsp_val : rsp_val;

  phy_regbus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .acc_done(acc_done),
    .rd_data(rd_data), .phy_addr(phy_addr), .phy_dout(phy_dout), .phy_dout_en(phy_dout_en),
    .phy_din(phy_din), .phy_ce_n(phy_ce_n), .phy_oe_n(phy_oe_n), .phy_rw(phy_rw),
    .phy_rst_n(phy_rst_n), .phy_irq_n(phy_irq_n), .phy_irq(phy_irq)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {write, addr[8:0], wdata[7:0], phy response[7:0]}
  localparam logic [25:0] VEC [0:5] = '{
    {1'b1, 9'h000, 8'h5A, 8'h00},
    {1'b0, 9'h1FF, 8'h00, 8'hC3},
    {1'b1, 9'h155, 8'hFF, 8'h00},
    {1'b0, 9'h0AA, 8'h00, 8'h00},
    {1'b0, 9'h101, 8'h00, 8'hFF},
    {1'b1, 9'h0F0, 8'h00, 8'h81}
  };

  task automatic run_access(input bit wr, input logic [8:0] a, input logic [7:0] d, input logic [7:0] r);
    logic [4:0] got, exp;
    while (!req_ready) @(negedge clk);
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = d; rsp_val = r;
    @(negedge clk);
    req = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      exp = {wr ? !(k >= 2 && k <= 5) : (k > 6),
             wr ? 1'b1 : !(k >= 2 && k <= 5),
             wr && k <= 6,
             wr ? (k == 7) : 1'b1,
             k == 7};
      got = {phy_ce_n, phy_oe_n, phy_dout_en, phy_rw, acc_done};
      chk(got == exp, wr ? "R2 R5 R10 write strobes" : "R3 R5 R10 read strobes", got, exp);
      if (k <= 6) chk(phy_addr == a, "R2 R3 address", phy_addr, a);
      if (wr && k <= 6) chk(phy_dout == d, "R2 write data", phy_dout, d);
      if (!wr && k >= 6) chk(rd_data == r, "R4 read capture", rd_data, r);
      if (k < 7) @(negedge clk);
    end
  endtask

  task automatic wait_rst_len(input string tag);
    int n = 0;
    bit saw_done = 0;
    while (!phy_rst_n && n < 100) begin
      chk(!req_ready, {tag, " R6 ready low in pulse"}, req_ready, 0);
      if (acc_done) saw_done = 1;
      @(negedge clk);
      n++;
    end
    chk(n == RST_LEN && n >= 11 && n <= 22, {tag, " pulse length"}, n, RST_LEN);
    chk(!saw_done, {tag, " no done during pulse"}, saw_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; soft_rst = 0; req = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    rsp_val = 8'h00; phy_irq_n = 1;
    repeat (3) @(negedge clk);
    chk({phy_ce_n, phy_oe_n, phy_dout_en, acc_done, req_ready, phy_rst_n} == 6'b110000,
        "R1 reset state", {phy_ce_n, phy_oe_n, phy_dout_en, acc_done, req_ready, phy_rst_n}, 6'b110000);
    rst_n = 1;
    wait_rst_len("R7");
    chk(req_ready, "R6 ready after pulse", req_ready, 1);

    for (int i = 0; i < 6; i++)
      run_access(VEC[i][25], VEC[i][24:16], VEC[i][15:8], VEC[i][7:0]);

    // R4: a write leaves the last read byte untouched
    run_access(1'b0, 9'h033, 8'h00, 8'h3C);
    run_access(1'b1, 9'h034, 8'h99, 8'h00);
    chk(rd_data == 8'h3C, "R4 held over write", rd_data, 8'h3C);

    // R6: requests raised mid-access are ignored
    while (!req_ready) @(negedge clk);
    req = 1; req_write = 0; req_addr = 9'h0AA; rsp_val = 8'h11;
    @(negedge clk);
    req = 1; req_write = 1; req_addr = 9'h155; req_wdata = 8'hEE;
    for (int k = 1; k <= 6; k++) begin
      chk(phy_addr == 9'h0AA && !phy_dout_en, "R6 busy holdoff", phy_addr, 9'h0AA);
      if (k == 5) req = 0;
      @(negedge clk);
    end
    chk(acc_done, "R5 done after holdoff read", acc_done, 1);
    repeat (3) begin
      @(negedge clk);
      chk(phy_ce_n && !phy_dout_en, "R6 no late access", {phy_ce_n, phy_dout_en}, 2'b10);
    end

    // R8: soft reset in the middle of a write strobe
    while (!req_ready) @(negedge clk);
    req = 1; req_write = 1; req_addr = 9'h077; req_wdata = 8'h42;
    @(negedge clk);
    req = 0;
    @(negedge clk);
    @(negedge clk);
    chk(!phy_ce_n, "R8 strobe active before abort", phy_ce_n, 0);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    chk(phy_ce_n && phy_oe_n && !phy_dout_en && !phy_rst_n, "R8 abort next cycle",
        {phy_ce_n, phy_oe_n, phy_dout_en, phy_rst_n}, 4'b1100);
    wait_rst_len("R8");
    repeat (2) begin
      chk(!acc_done, "R8 no done after abort", acc_done, 0);
      @(negedge clk);
    end

    // R6: request during a reset pulse is ignored
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    req = 1; req_write = 1; req_addr = 9'h011; req_wdata = 8'h22;
    repeat (5) begin
      chk(phy_ce_n && !phy_dout_en && !req_ready, "R6 holdoff in reset pulse",
          {phy_ce_n, phy_dout_en, req_ready}, 3'b100);
      @(negedge clk);
    end
    req = 0;
    while (!phy_rst_n) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(phy_ce_n && !phy_dout_en, "R6 no access after pulse", {phy_ce_n, phy_dout_en}, 2'b10);
    end
    run_access(1'b0, 9'h1E0, 8'h00, 8'h6D);

    // R9: interrupt registered on the clock
    phy_irq_n = 0;
    #1;
    chk(phy_irq == 0, "R9 not before edge", phy_irq, 0);
    @(negedge clk);
    chk(phy_irq == 1, "R9 asserted", phy_irq, 1);
    phy_irq_n = 1;
    @(negedge clk);
    chk(phy_irq == 0, "R9 released", phy_irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule